// File: doc/BRIEF.md
# Three-Stage Register-File Datapath

This block is a small execution datapath steered by a control word. Each clock it can accept one operation: two registers are read from a multi-port register file, the second operand is taken either from the register file or from a constant carried in the control word, a function unit computes a result with four status flags, and a write-back selector chooses between that result and an external data word. The chosen value is written into the destination register.

Pipeline registers split the work into three stages: read, execute and write-back. The clock period is therefore set by the slowest stage rather than by the whole chain. An operation presented at clock edge k shows its write on the write-back ports between edges k+1 and k+2, and it is committed into the register file at edge k+2. Operands are not forwarded. An operation must therefore be issued at least three edges after the operation that produces its source. A flush input cancels every operation that has not yet been committed.

Top module: `rfp_datapath`

## Requirements
- R1: While reset is low, and in the cycle after its release, `wb_valid`, `status`, `addr_out` and `data_out` are zero, and every register reads as zero.
- R2: With `b_const_sel`=1 the B operand is `const_val`; with `b_const_sel`=0 it is the register selected by `b_sel`.
- R3: `fn_sel` encodes PASS A=0, A+B=1, A-B=2, A+1=3, AND=4, OR=5, XOR=6, NOT A=7, all modulo 2^DATA_W.
- R4: `status` bit 0 is zero, bit 1 is negative (result MSB), bit 2 is carry and bit 3 is overflow. Carry is the adder carry-out for A+B and A+1, and 1 for A-B when A>=B unsigned. Overflow is signed overflow for add, subtract and increment. Both are 0 for PASS and the logic functions. The flags describe the function result and are registered with it.
- R5: With `wb_ext_sel`=1 the value written back is `ext_data` as sampled when the operation was presented; with 0 it is the function result.
- R6: A register is written only when its operation has `wr_en`=1. Register 0 is writable like any other register.
- R7: An operation accepted at edge k shows `wb_valid`, `wb_addr` and `wb_data` between edges k+1 and k+2 and is committed at edge k+2. Operations presented on consecutive edges complete on consecutive cycles.
- R8: A value written back is seen by any operation presented three or more edges after the producer.
- R9: `flush` high at edge e cancels the operations presented at edges e, e-1 and e-2. None of them writes a register, and `wb_valid` is low during the next cycle.
- R10: At an edge that accepts an operation, `addr_out` takes its A operand and `data_out` its B operand after the B selector. Both hold otherwise.
- R11: When `op_valid` is low the other control inputs are ignored, and no write results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| dst_sel | input | ADDR_W | Destination register |
| a_sel | input | ADDR_W | A read register |
| b_sel | input | ADDR_W | B read register |
| wr_en | input | 1 | Operation writes its destination |
| b_const_sel | input | 1 | B operand from constant field |
| fn_sel | input | 3 | Function select |
| wb_ext_sel | input | 1 | Write back external data instead of result |
| const_val | input | DATA_W | Constant field |
| ext_data | input | DATA_W | External data-in bus |
| flush | input | 1 | Cancel all uncommitted operations |
| addr_out | output | DATA_W | A operand of last accepted operation |
| data_out | output | DATA_W | B operand of last accepted operation |
| status | output | 4 | {overflow, carry, negative, zero} of last executed operation |
| wb_valid | output | 1 | A register write commits at the next edge |
| wb_addr | output | ADDR_W | Register being written |
| wb_data | output | DATA_W | Value being written |

## Verification
The bench builds the block with DATA_W=8 and ADDR_W=3, which is narrower than the 16-bit default. At this width, random operands often reach carry-out, signed overflow, zero results and negative results. A random stream can also reuse all eight registers, including register 0. The scoreboard records the issue cycle of every write, so the two-cycle write-back latency is checked on each item. Flushes and bubbles are checked by the absence of writes and by reading the affected registers back afterwards.

// File: rtl/rfp_pkg.sv
// Shared definitions for the register-file datapath: function codes and
// status flag positions. Assumes a 3-bit function select and 4-bit status.
package rfp_pkg;

    typedef enum logic [2:0] {
        FN_PASS = 3'd0,
        FN_ADD  = 3'd1,
        FN_SUB  = 3'd2,
        FN_INC  = 3'd3,
        FN_AND  = 3'd4,
        FN_OR   = 3'd5,
        FN_XOR  = 3'd6,
        FN_NOT  = 3'd7
    } fn_e;

    localparam int ST_W = 4;
    localparam int ST_Z = 0;
    localparam int ST_N = 1;
    localparam int ST_C = 2;
    localparam int ST_V = 3;

endpackage

// File: rtl/rfp_regfile.sv
// Register file with one write port and two combinational read ports.
// Assumes: write commits on the rising edge; reads do not see a write
// in the same cycle; every entry clears on synchronous active-low reset.
module rfp_regfile #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // Holds one register; loads when the write targets this entry.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (we && (waddr == ADDR_W'(i)))
                mem[i] <= wdata;
        end
    end

    // Read ports return the registered contents directly.
    always_comb begin
        rdata_a = mem[raddr_a];
        rdata_b = mem[raddr_b];
    end
endmodule

// File: rtl/rfp_func_unit.sv
// Combinational function unit: arithmetic and logic on two operands with
// zero/negative/carry/overflow flags. Assumes unsigned wrap-around results.
module rfp_func_unit
    import rfp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [2:0]        fn,
    output logic [DATA_W-1:0] result,
    output logic [ST_W-1:0]   flags
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] sum_add, sum_sub, sum_inc;
    logic            carry, ovf;

    // Widened adders give the carry-out in their top bit.
    always_comb begin
        sum_add = {1'b0, op_a} + {1'b0, op_b};
        sum_sub = {1'b0, op_a} + {1'b0, ~op_b} + {{DATA_W{1'b0}}, 1'b1};
        sum_inc = {1'b0, op_a} + {{DATA_W{1'b0}}, 1'b1};
    end

    // Select the result and the carry/overflow for the chosen function.
    always_comb begin
        result = op_a;
        carry  = 1'b0;
        ovf    = 1'b0;
        case (fn_e'(fn))
            FN_PASS: result = op_a;
            FN_ADD: begin
                result = sum_add[DATA_W-1:0];
                carry  = sum_add[DATA_W];
                ovf    = (op_a[MSB] == op_b[MSB]) && (result[MSB] != op_a[MSB]);
            end
            FN_SUB: begin
                result = sum_sub[DATA_W-1:0];
                carry  = sum_sub[DATA_W];
                ovf    = (op_a[MSB] != op_b[MSB]) && (result[MSB] != op_a[MSB]);
            end
            FN_INC: begin
                result = sum_inc[DATA_W-1:0];
                carry  = sum_inc[DATA_W];
                ovf    = !op_a[MSB] && result[MSB];
            end
            FN_AND:  result = op_a & op_b;
            FN_OR:   result = op_a | op_b;
            FN_XOR:  result = op_a ^ op_b;
            FN_NOT:  result = ~op_a;
            default: result = op_a;
        endcase
    end

    // Pack the flags in their fixed bit positions.
    always_comb begin
        flags       = '0;
        flags[ST_Z] = (result == '0);
        flags[ST_N] = result[MSB];
        flags[ST_C] = carry;
        flags[ST_V] = ovf;
    end
endmodule

// File: rtl/rfp_datapath.sv
// Three-stage datapath: register read, execute, write-back, each separated
// by a pipeline register so one operation may enter per clock.
// Assumes: no operand forwarding (sources must be three issue slots behind
// their producer); flush cancels every uncommitted operation, including the
// one in write-back; synchronous active-low reset.
module rfp_datapath
    import rfp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [ADDR_W-1:0] dst_sel,
    input  logic [ADDR_W-1:0] a_sel,
    input  logic [ADDR_W-1:0] b_sel,
    input  logic              wr_en,
    input  logic              b_const_sel,
    input  logic [2:0]        fn_sel,
    input  logic              wb_ext_sel,
    input  logic [DATA_W-1:0] const_val,
    input  logic [DATA_W-1:0] ext_data,
    input  logic              flush,
    output logic [DATA_W-1:0] addr_out,
    output logic [DATA_W-1:0] data_out,
    output logic [ST_W-1:0]   status,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);
    typedef struct packed {
        logic              valid;
        logic              we;
        logic [ADDR_W-1:0] dst;
        logic [2:0]        fn;
        logic              ext_sel;
        logic [DATA_W-1:0] a_val;
        logic [DATA_W-1:0] b_val;
        logic [DATA_W-1:0] ext;
    } ex_stage_t;

    typedef struct packed {
        logic              valid;
        logic              we;
        logic [ADDR_W-1:0] dst;
        logic              ext_sel;
        logic [DATA_W-1:0] result;
        logic [ST_W-1:0]   flags;
        logic [DATA_W-1:0] ext;
    } wb_stage_t;

    ex_stage_t         ex_q;
    wb_stage_t         wb_q;
    logic [DATA_W-1:0] rd_a, rd_b, opnd_b;
    logic [DATA_W-1:0] fu_result;
    logic [ST_W-1:0]   fu_flags;
    logic              accept;
    logic              commit;
    logic [DATA_W-1:0] commit_data;

    rfp_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (commit),
        .waddr   (wb_q.dst),
        .wdata   (commit_data),
        .raddr_a (a_sel),
        .rdata_a (rd_a),
        .raddr_b (b_sel),
        .rdata_b (rd_b)
    );

    // B-operand selector: register port B or the constant field.
    always_comb opnd_b = b_const_sel ? const_val : rd_b;

    always_comb accept = op_valid && !flush;

    // Read/execute boundary: capture operands and control of an accepted op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_q <= '0;
        end else begin
            ex_q.valid <= accept;
            if (accept) begin
                ex_q.we      <= wr_en;
                ex_q.dst     <= dst_sel;
                ex_q.fn      <= fn_sel;
                ex_q.ext_sel <= wb_ext_sel;
                ex_q.a_val   <= rd_a;
                ex_q.b_val   <= opnd_b;
                ex_q.ext     <= ext_data;
            end
        end
    end

    rfp_func_unit #(.DATA_W(DATA_W)) fu_i (
        .op_a   (ex_q.a_val),
        .op_b   (ex_q.b_val),
        .fn     (ex_q.fn),
        .result (fu_result),
        .flags  (fu_flags)
    );

    // Execute/write-back boundary: capture result and flags of a live op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_q <= '0;
        end else begin
            wb_q.valid <= ex_q.valid && !flush;
            if (ex_q.valid) begin
                wb_q.we      <= ex_q.we;
                wb_q.dst     <= ex_q.dst;
                wb_q.ext_sel <= ex_q.ext_sel;
                wb_q.result  <= fu_result;
                wb_q.flags   <= fu_flags;
                wb_q.ext     <= ex_q.ext;
            end
        end
    end

    // Write-back selector and commit qualifier (flush vetoes the commit).
    always_comb begin
        commit_data = wb_q.ext_sel ? wb_q.ext : wb_q.result;
        commit      = wb_q.valid && wb_q.we && !flush;
    end

    // Drive the observation ports from the stage registers.
    always_comb begin
        addr_out = ex_q.a_val;
        data_out = ex_q.b_val;
        status   = wb_q.flags;
        wb_valid = commit;
        wb_addr  = wb_q.dst;
        wb_data  = commit_data;
    end
endmodule

// File: rtl/rfp_datapath_chk.sv
// Property checker for the datapath, attached by bind. Observes ports only.
module rfp_datapath_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              wr_en,
    input logic [ADDR_W-1:0] dst_sel,
    input logic              wb_ext_sel,
    input logic [DATA_W-1:0] ext_data,
    input logic              flush,
    input logic              wb_valid,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [DATA_W-1:0] wb_data,
    input logic [3:0]        status
);
    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !wb_valid);

    // R7
    wb_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(op_valid && wr_en && !flush, 2));

    // R7
    wb_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_addr == $past(dst_sel, 2)));

    // R5
    ext_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && $past(wb_ext_sel, 2)) |-> (wb_data == $past(ext_data, 2)));

    // R4
    zero_not_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> !status[1]);

    // R11
    bubble_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> ##2 !wb_valid);
endmodule

bind rfp_datapath rfp_datapath_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .wr_en      (wr_en),
    .dst_sel    (dst_sel),
    .wb_ext_sel (wb_ext_sel),
    .ext_data   (ext_data),
    .flush      (flush),
    .wb_valid   (wb_valid),
    .wb_addr    (wb_addr),
    .wb_data    (wb_data),
    .status     (status)
);

// File: tb/rfp_datapath_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts each register write and queues it;
// the monitor pops and compares every write seen on the write-back ports.
module rfp_datapath_tb_top;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam int NREG = 1 << AW;

    typedef struct {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [3:0]    st;
        int            cyc;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0, wr_en = 1'b0, b_const_sel = 1'b0;
    logic          wb_ext_sel = 1'b0, flush = 1'b0;
    logic [AW-1:0] dst_sel = '0, a_sel = '0, b_sel = '0;
    logic [2:0]    fn_sel = '0;
    logic [DW-1:0] const_val = '0, ext_data = '0;
    logic [DW-1:0] addr_out, data_out, wb_data;
    logic [3:0]    status;
    logic          wb_valid;
    logic [AW-1:0] wb_addr;

    int            checks = 0, failures = 0, cyc = 0;
    item_t         sb_q[$];
    logic [DW-1:0] model [NREG];
    logic [AW-1:0] hz_d [2];
    logic          hz_v [2];

    rfp_datapath #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .dst_sel(dst_sel),
        .a_sel(a_sel), .b_sel(b_sel), .wr_en(wr_en), .b_const_sel(b_const_sel),
        .fn_sel(fn_sel), .wb_ext_sel(wb_ext_sel), .const_val(const_val),
        .ext_data(ext_data), .flush(flush), .addr_out(addr_out),
        .data_out(data_out), .status(status), .wb_valid(wb_valid),
        .wb_addr(wb_addr), .wb_data(wb_data)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference function unit: returns {V,C,N,Z,result}.
    function automatic logic [DW+3:0] ref_fu(input logic [2:0] f,
                                             input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
        logic [DW-1:0] r;
        logic c, v;
        int ua, ub, sa, sb, sr;
        ua = int'(a); ub = int'(b);
        sa = a[DW-1] ? ua - (1 << DW) : ua;
        sb = b[DW-1] ? ub - (1 << DW) : ub;
        c = 1'b0; v = 1'b0; sr = 0;
        case (f)
            3'd1: begin r = DW'(ua + ub); c = (ua + ub) >= (1 << DW); sr = sa + sb; end
            3'd2: begin r = DW'(ua - ub); c = ua >= ub; sr = sa - sb; end
            3'd3: begin r = DW'(ua + 1); c = (ua + 1) >= (1 << DW); sr = sa + 1; end
            3'd4: r = a & b;
            3'd5: r = a | b;
            3'd6: r = a ^ b;
            3'd7: r = ~a;
            default: r = a;
        endcase
        if (f == 3'd1 || f == 3'd2 || f == 3'd3)
            v = (sr > (1 << (DW - 1)) - 1) || (sr < -(1 << (DW - 1)));
        return {v, c, r[DW-1], (r == '0), r};
    endfunction

    // Driver: presents one operation for one edge and predicts its write.
    task automatic issue(input bit v, input bit we, input logic [AW-1:0] d,
                         input logic [AW-1:0] a, input logic [AW-1:0] b,
                         input bit bc, input logic [2:0] f, input bit xs,
                         input logic [DW-1:0] k, input logic [DW-1:0] x,
                         input bit fl, input bit kill, input string tag);
        logic [DW+3:0] res;
        item_t it;
        op_valid = v; wr_en = we; dst_sel = d; a_sel = a; b_sel = b;
        b_const_sel = bc; fn_sel = f; wb_ext_sel = xs; const_val = k;
        ext_data = x; flush = fl;
        if (v && we && !kill) begin
            res = ref_fu(f, model[a], bc ? k : model[b]);
            it.addr = d;
            it.data = xs ? x : res[DW-1:0];
            it.st   = res[DW+3:DW];
            it.cyc  = cyc + 2;
            it.tag  = tag;
            sb_q.push_back(it);
            model[d] = it.data;
        end
        hz_v[1] = hz_v[0]; hz_d[1] = hz_d[0];
        hz_v[0] = v && we; hz_d[0] = d;
        @(posedge clk); #1;
        op_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            issue(0, 0, '0, '0, '0, 0, 3'd0, 0, '0, '0, 0, 0, "");
    endtask

    function automatic bit hazard(input logic [AW-1:0] r);
        return (hz_v[0] && hz_d[0] == r) || (hz_v[1] && hz_d[1] == r);
    endfunction

    // Monitor: every observed write must match the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && wb_valid) begin
            if (sb_q.size() == 0) begin
                chk(0, "R6 R9 R11", "unexpected write addr", longint'(wb_addr), 0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                chk(wb_addr == it.addr && wb_data == it.data && status == it.st,
                    it.tag, "write {addr,data,status}",
                    {wb_addr, wb_data, status}, {it.addr, it.data, it.st});
                chk(cyc == it.cyc, "R7", "write-back cycle", cyc, it.cyc);
            end
        end
    end

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = '0;
        hz_v[0] = 0; hz_v[1] = 0; hz_d[0] = '0; hz_d[1] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs clear after reset
        chk(wb_valid == 0 && status == 0 && addr_out == 0 && data_out == 0,
            "R1", "post-reset outputs", {wb_valid, status, addr_out, data_out}, 0);
        // R1: every register reads zero (observed on addr_out/data_out)
        for (int i = 0; i < NREG; i++) begin
            issue(1, 0, '0, AW'(i), AW'(NREG - 1 - i), 0, 3'd0, 0, '0, '0, 0, 0, "");
            @(negedge clk);
            chk(addr_out == 0 && data_out == 0, "R1", "register read after reset",
                {addr_out, data_out}, 0);
        end

        // R5 R6 R7: load all registers back to back from the external bus, r0 included
        for (int i = 0; i < NREG; i++)
            issue(1, 1, AW'(i), AW'(NREG - 1), AW'(NREG - 1), 0, 3'd1, 1,
                  '0, DW'(i * 37 + 5), 0, 0, "R5 R6 R7 load");
        idle(2);

        // R10: operands appear on addr_out/data_out one edge after acceptance
        issue(1, 0, '0, 3'd3, 3'd5, 0, 3'd0, 0, '0, '0, 0, 0, "");
        @(negedge clk);
        chk(addr_out == model[3] && data_out == model[5], "R10", "reg operands",
            {addr_out, data_out}, {model[3], model[5]});
        // R2: constant selected as B operand
        issue(1, 0, '0, 3'd2, 3'd5, 1, 3'd0, 0, 8'h3C, '0, 0, 0, "");
        @(negedge clk);
        chk(addr_out == model[2] && data_out == 8'h3C, "R2", "constant operand",
            {addr_out, data_out}, {model[2], 8'h3C});

        // R6: register 0 written and read back; R8: three-slot visibility
        issue(1, 1, 3'd0, 3'd7, 3'd7, 0, 3'd0, 1, '0, 8'hA5, 0, 0, "R6 r0 write");
        idle(2);
        issue(1, 1, 3'd1, 3'd0, 3'd0, 0, 3'd0, 0, '0, '0, 0, 0, "R6 R8 r0 readback");
        // R6: wr_en low writes nothing
        issue(1, 0, 3'd2, 3'd3, 3'd3, 0, 3'd7, 0, '0, '0, 0, 0, "");
        idle(2);
        issue(1, 1, 3'd4, 3'd2, 3'd2, 0, 3'd0, 0, '0, '0, 0, 0, "R6 no-write readback");
        idle(2);

        // R11: bubble with write fields set is ignored
        issue(0, 1, 3'd3, 3'd0, 3'd0, 0, 3'd0, 1, '0, 8'hEE, 0, 0, "");
        idle(2);
        issue(1, 1, 3'd1, 3'd3, 3'd3, 0, 3'd0, 0, '0, '0, 0, 0, "R11 readback");
        idle(2);

        // R4: flag corners through constants
        issue(1, 1, 3'd4, 3'd7, 3'd7, 0, 3'd0, 1, '0, 8'h7F, 0, 0, "R5 setup");
        issue(1, 1, 3'd5, 3'd7, 3'd7, 0, 3'd0, 1, '0, 8'hFF, 0, 0, "R5 setup");
        issue(1, 1, 3'd6, 3'd7, 3'd7, 0, 3'd0, 1, '0, 8'h00, 0, 0, "R5 setup");
        idle(2);
        issue(1, 1, 3'd7, 3'd4, 3'd0, 1, 3'd1, 0, 8'h01, '0, 0, 0, "R3 R4 add ovf");
        issue(1, 1, 3'd7, 3'd5, 3'd0, 1, 3'd1, 0, 8'h01, '0, 0, 0, "R3 R4 add carry zero");
        issue(1, 1, 3'd7, 3'd4, 3'd0, 1, 3'd2, 0, 8'h7F, '0, 0, 0, "R3 R4 sub equal");
        issue(1, 1, 3'd7, 3'd4, 3'd0, 0, 3'd3, 0, '0, '0, 0, 0, "R3 R4 inc ovf");
        issue(1, 1, 3'd7, 3'd6, 3'd0, 1, 3'd2, 0, 8'h01, '0, 0, 0, "R3 R4 sub borrow");
        issue(1, 1, 3'd7, 3'd6, 3'd0, 0, 3'd7, 0, '0, '0, 0, 0, "R3 R4 not");
        idle(2);

        // R9: flush cancels the op at the flush edge and the two before it
        issue(1, 1, 3'd1, 3'd7, 3'd7, 0, 3'd0, 1, '0, 8'h11, 0, 0, "R9 survivor");
        issue(1, 1, 3'd2, 3'd7, 3'd7, 0, 3'd0, 1, '0, 8'h22, 0, 1, "");
        issue(1, 1, 3'd3, 3'd7, 3'd7, 0, 3'd0, 1, '0, 8'h33, 0, 1, "");
        issue(1, 1, 3'd4, 3'd7, 3'd7, 0, 3'd0, 1, '0, 8'h44, 1, 1, "");
        @(negedge clk);
        chk(wb_valid == 0, "R9", "wb_valid after flush", wb_valid, 0);
        hz_v[0] = 0; hz_v[1] = 0;
        issue(1, 1, 3'd5, 3'd1, 3'd2, 0, 3'd6, 0, '0, '0, 0, 0, "R9 readback r1^r2");
        issue(1, 1, 3'd6, 3'd3, 3'd4, 0, 3'd5, 0, '0, '0, 0, 0, "R9 readback r3|r4");
        idle(2);

        // R2 R3 R4 R5 R8: random stream honouring the three-slot distance
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] ra, rb;
            bit v, we, bc, xs;
            v = ($urandom_range(0, 7) != 0);
            we = ($urandom_range(0, 7) != 0);
            bc = $urandom_range(0, 1);
            xs = ($urandom_range(0, 3) == 0);
            do ra = AW'($urandom); while (hazard(ra));
            do rb = AW'($urandom); while (hazard(rb));
            issue(v, we, AW'($urandom), ra, rb, bc, 3'($urandom), xs,
                  DW'($urandom), DW'($urandom), 0, 0, "R2 R3 R4 R5 R8 random");
        end
        idle(4);
        @(negedge clk);
        chk(sb_q.size() == 0, "R7", "scoreboard drained", sb_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule